// File: doc/BRIEF.md
# Vector length configuration unit

This unit executes the three configuration instructions of a vector extension. Each one asks for an application vector length (AVL) and an element layout (vtype). The three forms differ only in where those two requests come from. The first takes the AVL from a scalar register and the vtype from an immediate. The second takes both from scalar registers. The third takes both from immediates.

The unit works out the largest legal vector length for the requested layout. The register length is 128 bits and the widest element is 64 bits. The unit then picks the new vector length, and raises the illegal flag when the layout cannot be supported. It updates its vl, vtype and vstart registers and returns the new length as the destination-register writeback value. An instruction is presented with a one-cycle issue strobe together with its two scalar operand values. One clock later a done strobe appears, with registered results.

A separate write port lets the trap or CSR path load vstart. A configuration instruction always clears vstart.

Top module: `vcfg_unit`

## Requirements
- R1: An issued word is accepted only when bits 6:0 equal 1010111 and bits 14:12 equal 111. Any other word gives no done pulse and leaves vl and vtype unchanged.
- R2: The form is chosen by the top two bits of the word.
  - Bit 31 = 0: vtype comes from word bits 30:20, and the AVL from the rs1 operand.
  - Bits 31:30 = 10: vtype comes from the rs2 operand, and the AVL from the rs1 operand.
  - Bits 31:30 = 11: vtype comes from word bits 29:20, and the AVL is word bits 19:15 zero-extended.
- R3: The vtype fields are as follows, and a legal request is stored in vtype unchanged, including bits 7:6.
  - Bits 2:0 hold a signed LMUL code: 0..3 give LMUL 1, 2, 4, 8, and 7, 6, 5 give 1/2, 1/4, 1/8.
  - Bits 5:3 hold the SEW code, with SEW = 8 << code.
  - Bit 6 is tail-agnostic and bit 7 is mask-agnostic.
- R4: VLMAX = (128 / SEW) × LMUL, and vl never exceeds 128.
- R5: The request is illegal when any of these holds:
  - the LMUL code is 4;
  - the SEW code is above 3;
  - SEW > min(LMUL, 1) × 64;
  - any requested bit from 8 to 31 is set.
  An illegal request sets vtype to bit 31 alone and sets vl to 0.
- R6: The new vl depends on the rs1 index (bits 19:15) and the rd index (bits 11:7).
  - VLMAX = 0 gives vl = 0.
  - rs1 = 0 and rd = 0 gives vl = min(current vl, VLMAX).
  - rs1 = 0 and rd ≠ 0 gives vl = VLMAX.
  - rs1 ≠ 0 gives vl = min(AVL, VLMAX).
- R7: The immediate-AVL form always uses min(uimm, VLMAX), even when the uimm is 0.
- R8: The done pulse is high in the cycle after the issue strobe. In that cycle rd_data_o holds the new vl zero-extended to 32 bits.
- R9: An accepted configuration instruction sets vstart to 0. Otherwise a vstart write loads vstart_wdata_i. When both happen in the same cycle, the clear wins.
- R10: After reset, vl = 0, vstart = 0, vtype = 0x80000000 and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction issue strobe |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | rs1 operand value |
| rs2_val_i | input | 32 | rs2 operand value |
| vstart_we_i | input | 1 | vstart write enable from the trap/CSR path |
| vstart_wdata_i | input | 7 | vstart write data |
| done_o | output | 1 | Result-valid strobe, one cycle after issue |
| rd_data_o | output | 32 | Destination writeback value (new vl) |
| vl_o | output | 8 | Current vl register |
| vtype_o | output | 32 | Current vtype register |
| vstart_o | output | 7 | Current vstart register |

## Verification
Every one of the 256 values of vtype bits 7:0 is sent through all three forms, under each of the four AVL rules, and the expected VLMAX is computed by integer multiply and divide.

- The rule that keeps the current vl runs right after a configuration with a different layout, so its clamp sees a vl that VLMAX can cut down.
- Register-AVL requests swing above and below VLMAX, which separates clamping from pass-through.
- Immediate-AVL requests cover a uimm of zero, which distinguishes "treated as rs1 ≠ 0" from the x0 rules.
- Directed cases cover reserved high vtype bits in each form, words with the wrong opcode or funct3, and a vstart write that collides with a configuration.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int unsigned XLEN = 32;
  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [2:0] F3_CFG = 3'b111;

  typedef enum logic [1:0] {
    FORM_REG_AVL_IMM_VT = 2'd0,
    FORM_REG_AVL_REG_VT = 2'd1,
    FORM_IMM_AVL_IMM_VT = 2'd2
  } cfg_form_e;

  typedef struct packed {
    logic             is_cfg;
    cfg_form_e        form;
    logic             rd_zero;
    logic             rs1_zero;
    logic [XLEN-1:0]  avl;
    logic [XLEN-1:0]  vtype;
  } cfg_req_t;
endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
(
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output cfg_req_t        req_o
);
  logic [4:0] rs1_idx;
  logic [4:0] rd_idx;

  assign rs1_idx = insn_i[19:15];
  assign rd_idx  = insn_i[11:7];

  always_comb begin
    req_o.is_cfg  = (insn_i[6:0] == OPC_VEC) && (insn_i[14:12] == F3_CFG);
    req_o.rd_zero = (rd_idx == 5'd0);
    if (!insn_i[31]) begin
      req_o.form     = FORM_REG_AVL_IMM_VT;
      req_o.vtype    = XLEN'(insn_i[30:20]);
      req_o.avl      = rs1_val_i;
      req_o.rs1_zero = (rs1_idx == 5'd0);
    end else if (!insn_i[30]) begin
      req_o.form     = FORM_REG_AVL_REG_VT;
      req_o.vtype    = rs2_val_i;
      req_o.avl      = rs1_val_i;
      req_o.rs1_zero = (rs1_idx == 5'd0);
    end else begin
      // immediate AVL: the rs1 field is the AVL, never an x0 marker
      req_o.form     = FORM_IMM_AVL_IMM_VT;
      req_o.vtype    = XLEN'(insn_i[29:20]);
      req_o.avl      = XLEN'(rs1_idx);
      req_o.rs1_zero = 1'b0;
    end
  end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  localparam int unsigned VL_W = $clog2(VLEN) + 1
) (
  input  logic [5:0]      code_i,
  input  logic            resv_i,
  output logic            illegal_o,
  output logic [VL_W-1:0] vlmax_o
);
  localparam int unsigned ELEN_LG = $clog2(ELEN);

  logic [2:0]      lmul_code;
  logic [2:0]      sew_code;
  logic            frac;
  logic [1:0]      frac_sh;
  logic [3:0]      sew_lg;
  logic [3:0]      lim_lg;
  logic            bad_code;
  logic            too_wide;
  logic [VL_W-1:0] base;
  logic [VL_W-1:0] scaled;

  assign lmul_code = code_i[2:0];
  assign sew_code  = code_i[5:3];
  assign frac      = lmul_code[2];
  // fractional LMUL 1/2^k: k is the negated code (7->1, 6->2, 5->3)
  assign frac_sh   = 2'(3'd0 - lmul_code);
  assign sew_lg    = 4'd3 + {2'b00, sew_code[1:0]};
  assign lim_lg    = 4'(ELEN_LG) - (frac ? {2'b00, frac_sh} : 4'd0);
  assign bad_code  = (lmul_code == 3'b100) || sew_code[2];
  assign too_wide  = sew_lg > lim_lg;

  assign base   = VL_W'(VLEN) >> sew_lg;
  assign scaled = frac ? (base >> frac_sh) : (base << lmul_code[1:0]);

  assign illegal_o = resv_i | bad_code | too_wide;
  assign vlmax_o   = illegal_o ? '0 : scaled;
endmodule

// File: rtl/vcfg_vlsel.sv
module vcfg_vlsel
  import vcfg_pkg::*;
#(
  parameter int unsigned VL_W = 8
) (
  input  logic [VL_W-1:0] vlmax_i,
  input  logic [VL_W-1:0] cur_vl_i,
  input  logic [XLEN-1:0] avl_i,
  input  logic            rd_zero_i,
  input  logic            rs1_zero_i,
  output logic [VL_W-1:0] vl_o
);
  logic [XLEN-1:0] vlmax_x;

  assign vlmax_x = XLEN'(vlmax_i);

  always_comb begin
    if (vlmax_i == '0) begin
      vl_o = '0;
    end else if (rs1_zero_i) begin
      if (rd_zero_i) vl_o = (cur_vl_i > vlmax_i) ? vlmax_i : cur_vl_i;
      else           vl_o = vlmax_i;
    end else begin
      vl_o = (avl_i > vlmax_x) ? vlmax_i : avl_i[VL_W-1:0];
    end
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64,
  localparam int unsigned VL_W = $clog2(VLEN) + 1,
  localparam int unsigned VS_W = $clog2(VLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [31:0]     insn_i,
  input  logic [31:0]     rs1_val_i,
  input  logic [31:0]     rs2_val_i,
  input  logic            vstart_we_i,
  input  logic [VS_W-1:0] vstart_wdata_i,
  output logic            done_o,
  output logic [31:0]     rd_data_o,
  output logic [VL_W-1:0] vl_o,
  output logic [31:0]     vtype_o,
  output logic [VS_W-1:0] vstart_o
);
  localparam logic [XLEN-1:0] VTYPE_ILL = {1'b1, {(XLEN-1){1'b0}}};

  cfg_req_t        req;
  logic            illegal;
  logic [VL_W-1:0] vlmax;
  logic [VL_W-1:0] new_vl;
  logic            take;
  logic            vs_en;

  logic            done_q,   done_d;
  logic [VL_W-1:0] vl_q,     vl_d;
  logic [XLEN-1:0] vtype_q,  vtype_d;
  logic [VS_W-1:0] vstart_q, vstart_d;
  logic [XLEN-1:0] rd_q,     rd_d;

  vcfg_decode u_dec (
    .insn_i    (insn_i),
    .rs1_val_i (rs1_val_i),
    .rs2_val_i (rs2_val_i),
    .req_o     (req)
  );

  vcfg_vlmax #(.VLEN(VLEN), .ELEN(ELEN)) u_vlmax (
    .code_i    (req.vtype[5:0]),
    .resv_i    (|req.vtype[XLEN-1:8]),
    .illegal_o (illegal),
    .vlmax_o   (vlmax)
  );

  vcfg_vlsel #(.VL_W(VL_W)) u_vlsel (
    .vlmax_i    (vlmax),
    .cur_vl_i   (vl_q),
    .avl_i      (req.avl),
    .rd_zero_i  (req.rd_zero),
    .rs1_zero_i (req.rs1_zero),
    .vl_o       (new_vl)
  );

  assign take  = issue_i & req.is_cfg;
  assign vs_en = take | vstart_we_i;

  always_comb begin
    done_d   = take;
    vl_d     = new_vl;
    vtype_d  = illegal ? VTYPE_ILL : req.vtype;
    rd_d     = XLEN'(new_vl);
    vstart_d = take ? '0 : vstart_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      vl_q     <= '0;
      vtype_q  <= VTYPE_ILL;
      vstart_q <= '0;
      rd_q     <= '0;
    end else begin
      done_q <= done_d;
      if (take) begin
        vl_q    <= vl_d;
        vtype_q <= vtype_d;
        rd_q    <= rd_d;
      end
      if (vs_en) vstart_q <= vstart_d;
    end
  end

  assign done_o    = done_q;
  assign rd_data_o = rd_q;
  assign vl_o      = vl_q;
  assign vtype_o   = vtype_q;
  assign vstart_o  = vstart_q;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VL_W = $clog2(VLEN) + 1,
  localparam int unsigned VS_W = $clog2(VLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_i,
  input logic            done_o,
  input logic [31:0]     rd_data_o,
  input logic [VL_W-1:0] vl_o,
  input logic [31:0]     vtype_o,
  input logic [VS_W-1:0] vstart_o
);
  // R8
  done_follows_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(issue_i));

  // R8
  rd_matches_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_data_o == 32'(vl_o)));

  // R5
  vill_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtype_o[31] |-> (vl_o == '0) && (vtype_o[30:0] == '0));

  // R4
  vl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(vl_o) <= VLEN);

  // R9
  vstart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vstart_o == '0));

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(issue_i) |-> $stable(vl_o) && $stable(vtype_o) && !done_o);
endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .issue_i   (issue_i),
  .done_o    (done_o),
  .rd_data_o (rd_data_o),
  .vl_o      (vl_o),
  .vtype_o   (vtype_o),
  .vstart_o  (vstart_o)
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam logic [6:0] OP = 7'b1010111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] rs1v = '0;
  logic [31:0] rs2v = '0;
  logic        vs_we = 1'b0;
  logic [6:0]  vs_wd = '0;
  logic        done;
  logic [31:0] rd_data;
  logic [7:0]  vl;
  logic [31:0] vtype;
  logic [6:0]  vstart;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int m_vl = 0;
  logic [31:0] m_vtype = 32'h8000_0000;

  always #5 clk = ~clk;

  vcfg_unit u_vcfg_unit (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .insn_i(insn),
    .rs1_val_i(rs1v), .rs2_val_i(rs2v), .vstart_we_i(vs_we),
    .vstart_wdata_i(vs_wd), .done_o(done), .rd_data_o(rd_data),
    .vl_o(vl), .vtype_o(vtype), .vstart_o(vstart)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_vlmax(logic [31:0] vt);
    int lm, vs, sew, num, den;
    if ((vt >> 8) != 0) return 0;
    lm = int'(vt[2:0]);
    vs = int'(vt[5:3]);
    if (lm == 4 || vs > 3) return 0;
    sew = 8 << vs;
    num = (lm < 4) ? (1 << lm) : 1;
    den = (lm < 4) ? 1 : (1 << (8 - lm));
    if (sew * den > ELEN) return 0;
    return (VLEN * num) / (sew * den);
  endfunction

  function automatic logic [31:0] f_vi(logic [4:0] rd, logic [4:0] rs1, logic [10:0] z);
    return {1'b0, z, rs1, 3'b111, rd, OP};
  endfunction
  function automatic logic [31:0] f_vr(logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {2'b10, 5'b0, rs2, rs1, 3'b111, rd, OP};
  endfunction
  function automatic logic [31:0] f_ii(logic [4:0] rd, logic [4:0] u, logic [9:0] z);
    return {2'b11, z, u, 3'b111, rd, OP};
  endfunction

  // issue a configuration, update the model, compare one cycle later
  task automatic do_cfg(string tag, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                        logic [31:0] vt_req, int avl, bit rdz, bit rs1z);
    int vmax;
    vmax = ref_vlmax(vt_req);
    if (vmax == 0) begin
      m_vl = 0;
      m_vtype = 32'h8000_0000;
    end else begin
      m_vtype = vt_req;
      if (rs1z) m_vl = rdz ? ((m_vl > vmax) ? vmax : m_vl) : vmax;
      else      m_vl = (avl > vmax || avl < 0) ? vmax : avl;
    end
    @(negedge clk);
    insn = w; rs1v = a; rs2v = b; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    check_eq({tag, " R8 done"}, 32'(done), 32'd1);
    check_eq({tag, " R6 vl"}, 32'(vl), 32'(m_vl));
    check_eq({tag, " R5 vtype"}, vtype, m_vtype);
    check_eq({tag, " R8 rd_data"}, rd_data, 32'(m_vl));
  endtask

  task automatic do_ignored(string tag, logic [31:0] w);
    @(negedge clk);
    insn = w; rs1v = 32'd3; rs2v = 32'd0; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    check_eq({tag, " R1 no done"}, 32'(done), 32'd0);
    check_eq({tag, " R1 vl kept"}, 32'(vl), 32'(m_vl));
    check_eq({tag, " R1 vtype kept"}, vtype, m_vtype);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_eq("R10 done", 32'(done), 32'd0);
    check_eq("R10 vl", 32'(vl), 32'd0);
    check_eq("R10 vstart", 32'(vstart), 32'd0);
    check_eq("R10 vtype", vtype, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep vtype[7:0] over all forms and vl rules (R2 R3 R4 R5 R6 R7)
    for (int vt = 0; vt < 256; vt++) begin
      logic [31:0] v, v2;
      int avl;
      v  = 32'(vt);
      v2 = 32'((vt + 37) % 256);
      avl = (vt * 3) % 200;
      do_cfg("R6 rs1!=0", f_vi(5'd3, 5'd5, v[10:0]), 32'(avl), 0, v, avl, 0, 0);
      do_cfg("R6 rs1=0 rd!=0", f_vi(5'd4, 5'd0, v2[10:0]), 32'd999, 0, v2, 999, 0, 1);
      do_cfg("R6 rs1=0 rd=0", f_vi(5'd0, 5'd0, v[10:0]), 32'd999, 0, v, 999, 1, 1);
      do_cfg("R2 reg vtype", f_vr(5'd1, 5'd7, 5'd9), 32'(300 - vt), v, v, 300 - vt, 0, 0);
      do_cfg("R7 imm avl", f_ii(5'd2, v[4:0], v[9:0]), 32'hFFFF_FFFF, 0, v, vt % 32, 0, 0);
    end

    // R5 reserved bits in each form
    do_cfg("R5 zimm bit9", f_vi(5'd1, 5'd1, 11'h208), 32'd4, 0, 32'h208, 4, 0, 0);
    do_cfg("R3 legal base", f_vi(5'd1, 5'd1, 11'h0C0), 32'd50, 0, 32'h0C0, 50, 0, 0);
    do_cfg("R5 rs2 bit20", f_vr(5'd1, 5'd1, 5'd2), 32'd4, 32'h0010_0000, 32'h0010_0000, 4, 0, 0);
    do_cfg("R3 legal base2", f_vr(5'd1, 5'd1, 5'd2), 32'd9, 32'h0000_0003, 32'h3, 9, 0, 0);
    do_cfg("R5 rs2 bit31", f_vr(5'd1, 5'd1, 5'd2), 32'd4, 32'h8000_0000, 32'h8000_0000, 4, 0, 0);
    do_cfg("R5 zimm10 bit8", f_ii(5'd1, 5'd6, 10'h100), 0, 0, 32'h100, 6, 0, 0);
    do_cfg("R7 uimm zero", f_ii(5'd0, 5'd0, 10'h000), 0, 0, 32'h0, 0, 0, 0);
    do_cfg("R4 lmul8 sew8", f_vi(5'd1, 5'd1, 11'h003), 32'd1000, 0, 32'h3, 1000, 0, 0);

    // R1 words that are not configuration instructions
    do_ignored("R1 funct3", {17'h0AAAA, 3'b000, 5'd1, OP});
    do_ignored("R1 opcode", {17'h0AAAA, 3'b111, 5'd1, 7'b0110011});

    // R9 vstart write, clear on configuration, clear wins on collision
    @(negedge clk);
    vs_we = 1'b1; vs_wd = 7'd37;
    @(negedge clk);
    vs_we = 1'b0;
    check_eq("R9 vstart write", 32'(vstart), 32'd37);
    do_cfg("R9 cfg", f_vi(5'd1, 5'd0, 11'h008), 0, 0, 32'h8, 0, 0, 1);
    check_eq("R9 vstart cleared", 32'(vstart), 32'd0);
    @(negedge clk);
    vs_we = 1'b1; vs_wd = 7'd21;
    @(negedge clk);
    vs_we = 1'b0;
    check_eq("R9 vstart write2", 32'(vstart), 32'd21);
    @(negedge clk);
    vs_we = 1'b1; vs_wd = 7'd99;
    insn = f_vi(5'd1, 5'd0, 11'h008); issue = 1'b1;
    @(negedge clk);
    vs_we = 1'b0; issue = 1'b0;
    check_eq("R9 collision clear wins", 32'(vstart), 32'd0);
    check_eq("R8 collision done", 32'(done), 32'd1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule